// File: doc/BRIEF.md
# Dot-Matrix Progressive Reveal Animator

This block drives an 8x8 LED matrix that is scanned one row at a time. It holds a single fixed 8x8 glyph and plays a two-phase reveal animation on it. In the first phase the visible set of columns starts as the two edge columns and widens inward until the whole glyph is lit. In the second phase only the two centre rows are visible at first, and the band then grows outward until the glyph is whole again. The full glyph is held for one more step, and then the sequence starts over.

One free-running divider produces two single-cycle enables in the system clock domain. The shorter one moves the scan to the next row. The longer one advances the animation. The row-select output is one-hot. The column output is active low: a 0 lights the LED in that column of the selected row, and the value 8'hFF is a blank row. An enable input blanks the display without stopping the scan or the animation.

Top module: `dot_reveal`

## Requirements
- R1: `row_sel` is always one-hot. After reset it is 8'b0000_0001. It moves to the next higher bit once every 2^SCAN_LOG2 clocks, and after bit 7 it wraps to bit 0. The selected row index r is the position of its set bit.
- R2: The glyph row r is `GLYPH[8r+7:8r]`, and its bit c corresponds to column c. When en is 1, row r is visible and column c is inside the window, `col_n[c]` is the inverse of the glyph bit, so a lit pixel reads 0.
- R3: While en is 0, `col_n` is 8'hFF. Scanning and the animation keep advancing while the display is blanked.
- R4: The animation stage s starts at 0 after reset and steps once every 2^STEP_LOG2 clocks. It runs through the values 0..8 in order and then wraps back to 0.
- R5: Column phase, stages 0..3, with L = s: column c is shown only if c <= L or c >= 7-L. Every other bit of `col_n` is 1.
- R6: Row phase, stages 4..7, with L = s-4: row r is shown only if 3-L <= r <= 4+L. All columns are open. In the scan slot of a hidden row, `col_n` is 8'hFF.
- R7: Stage 8 shows the whole glyph. The stage after it is stage 0.
- R8: The reset input `rst` is synchronous and active high. It clears the divider and sets the row index to 0 and the stage to 0. The counts in R1 and R4 are taken from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Display enable; 0 blanks the columns |
| row_sel | output | 8 | One-hot select of the row being scanned |
| col_n | output | 8 | Active-low column data for the selected row |

## Verification
A wrong row index shows within one scan slot, because `col_n` then carries the pattern of a different glyph row. A divider that is off by even one count moves the row change and the stage change away from the clock edges the bench predicts. A wrong stage or a bad window edge shows within one animation step, as a column or row that is lit or dark when it should not be. The bench sweeps every clock of more than two complete animation cycles with short dividers. It checks both outputs on every clock against values computed from the clock count, with blanking windows and a reset in the middle of the run.

// File: rtl/dot_reveal.sv
module dot_reveal #(
  parameter int          SCAN_LOG2 = 9,
  parameter int          STEP_LOG2 = 25,
  parameter logic [63:0] GLYPH     = 64'h3C66_C3FF_FFC3_663C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [7:0] row_sel,
  output logic [7:0] col_n
);

  localparam logic [3:0] LAST_STAGE = 4'd8;

  logic [STEP_LOG2-1:0] div;
  logic [2:0]           row_idx;
  logic [3:0]           stage;
  logic [7:0]           col_mask;
  logic                 row_vis;

  wire scan_tick = &div[SCAN_LOG2-1:0];
  wire step_tick = &div;
  wire col_phase = (stage < 4'd4);
  wire row_phase = (stage >= 4'd4) && (stage < LAST_STAGE);
  wire [2:0] lvl = {1'b0, stage[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      div     <= '0;
      row_idx <= '0;
      stage   <= '0;
    end else begin
      div <= div + 1'b1;
      if (scan_tick) row_idx <= row_idx + 3'd1;
      if (step_tick) stage <= (stage == LAST_STAGE) ? 4'd0 : stage + 4'd1;
    end
  end

  always_comb begin
    for (int c = 0; c < 8; c++)
      col_mask[c] = !col_phase || (c <= int'(lvl)) || (c >= 7 - int'(lvl));
    row_vis = !row_phase ||
              ((int'(row_idx) >= 3 - int'(lvl)) && (int'(row_idx) <= 4 + int'(lvl)));
  end

  assign row_sel = 8'd1 << row_idx;
  assign col_n   = (en && row_vis) ? ~(GLYPH[{row_idx, 3'b000} +: 8] & col_mask) : 8'hFF;

  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(row_sel) == 1);

  assert_row_advance_R1: assert property (@(posedge clk) disable iff (rst)
    scan_tick |=> row_sel == {$past(row_sel[6:0]), $past(row_sel[7])});

  assert_row_steady_R1: assert property (@(posedge clk) disable iff (rst)
    !scan_tick |=> $stable(row_sel));

  assert_blank_R3: assert property (@(posedge clk) disable iff (rst)
    !en |-> &col_n);

  assert_stage_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !step_tick |=> $stable(stage));

  assert_stage_range_R4: assert property (@(posedge clk) disable iff (rst)
    stage <= LAST_STAGE);

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (step_tick && stage == LAST_STAGE) |=> stage == 4'd0);

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (row_sel == 8'd1) && (stage == 4'd0));

endmodule

// File: tb/dot_reveal_tb.sv
module dot_reveal_tb;
  localparam int          SL = 2;
  localparam int          TL = 6;
  localparam logic [63:0] G  = 64'h81C3_E75A_A5E7_3C18;

  logic clk = 1'b0, rst = 1'b1, en = 1'b1;
  logic [7:0] row_sel, col_n;
  int checks = 0, errors = 0, n = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dot_reveal #(.SCAN_LOG2(SL), .STEP_LOG2(TL), .GLYPH(G)) u_dut (
    .clk(clk), .rst(rst), .en(en), .row_sel(row_sel), .col_n(col_n));

  function automatic logic [7:0] exp_col(int k, logic e);
    int r = (k >> SL) % 8;
    int s = (k >> TL) % 9;
    int l = s % 4;
    logic [7:0] m = 8'hFF;
    bit vis = 1'b1;
    if (s < 4)
      for (int c = 0; c < 8; c++) m[c] = (c <= l) || (c >= 7 - l);
    else if (s < 8)
      vis = (r >= 3 - l) && (r <= 4 + l);
    if (!e || !vis) return 8'hFF;
    return ~(G[r*8 +: 8] & m);
  endfunction

  function automatic string tag(int k, logic e);
    int s = (k >> TL) % 9;
    if (!e) return "R3";
    if (s < 4) return "R5";
    if (s < 8) return "R6";
    return "R7";
  endfunction

  task automatic check_now(string rq_row);
    logic [7:0] er = 8'd1 << ((n >> SL) % 8);
    logic [7:0] ec = exp_col(n, en);
    checks += 2;
    if (row_sel !== er) begin
      errors++;
      $display("FAIL %s n=%0d row_sel=%b expected %b", rq_row, n, row_sel, er);
    end
    if (col_n !== ec) begin
      errors++;
      $display("FAIL %s/R2 n=%0d col_n=%b expected %b", tag(n, en), n, col_n, ec);
    end
  endtask

  task automatic run(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      n++;
      #1 en = !(((n / 100) % 7) == 3);
      #0.5 check_now(((n >> TL) % 9 == 0 && n >= 576) ? "R4/R1" : "R1");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check_now("R8");
    rst = 1'b0;
    n = 0;
    #0.5 check_now("R8");
    run(2 * 9 * 64 + 40);
    @(negedge clk) rst = 1'b1;
    en = 1'b1;
    repeat (2) @(posedge clk);
    #1 n = 0;
    check_now("R8");
    rst = 1'b0;
    run(300);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule